// File: doc/BRIEF.md
# Triggered Sample Pipeline Event Framer

This block stands in for analog sample storage on a front-end board. Every sample strobe writes one 12-bit word for each channel into a circular digital pipeline, one row per strobe. Writing never stops, so the block has no deadtime. When a level-1 accept (L1A) pulse arrives, the block records where its window starts: a programmable number of samples back from the current write position. It also records a 24-bit event number. Both go into a small event queue.

A readout engine drains the queue one event at a time. Each event goes out as exactly one raw MAC-style frame on a byte-wide stream, one byte per clock, marked with valid, start and end flags. The frame holds the addresses and the ethertype, the event number, and the window's samples in channel-major order. It closes with a CRC-32 check sequence. The event queue does not copy the samples. Each queue entry is only a row pointer into the pipeline. For this reason the pipeline depth must cover the largest latency plus the time needed to drain a full queue.

Top module: `sfp_top`

## Requirements
- R1: Every cycle with `sampleStrobe` high writes all `NUM_CH` samples, channel c at bits [12c+11:12c] of `sampleData`, into the next pipeline row. Writing never pauses for triggers or readout.
- R2: Let N be the number of strobes accepted before the L1A cycle, and let L be the value on `latency` in that cycle (WIN <= L, L + queue drain time < DEPTH in samples). The frame then carries samples N-L through N-L+WIN-1 of every channel.
- R3: Every L1A accepted while the queue has room produces exactly one frame. Frames leave in L1A order. L1As on consecutive cycles are all accepted.
- R4: The frame layout is, in order:
  - seven bytes 0x55 and one byte 0xD5;
  - the destination address (6 bytes, MSB first);
  - the source address (6 bytes, MSB first);
  - the ethertype (2 bytes, MSB first);
  - the event number (3 bytes, MSB first);
  - the payload;
  - a 4-byte check sequence.

  The frame is 29 + 2*NUM_CH*WIN bytes long.
- R5: The payload is channel-major. All WIN samples of channel 0 come first, oldest first. Each sample is sent as two bytes, MSB first, with the 12-bit value zero-padded so the top 4 bits are 0.
- R6: The check sequence is CRC-32 (reflected polynomial 0xEDB88320, initial value all ones) over the bytes from the destination address through the payload. It is complemented and sent least significant byte first.
- R7: The event number is a 24-bit count of every L1A since reset, including dropped ones.
- R8: The queue holds EVQ events, counting the one being sent. An L1A that finds the queue full is dropped. It sets the sticky `lostFlag` and increments the saturating `lostCount`.
- R9: `txSof` marks the first preamble byte and `txEof` marks the last check byte. `txValid` stays high for the whole frame, and at least one idle cycle separates frames.
- R10: During and after reset, `txValid`, `lostFlag` and `lostCount` are zero, and event numbering restarts at 0.
- R11: An L1A in the same cycle as a strobe counts N without that cycle's sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStrobe | input | 1 | One pipeline row is written this cycle |
| sampleData | input | NUM_CH*12 | Per-channel samples, channel c at [12c+11:12c] |
| l1a | input | 1 | Level-1 accept pulse |
| latency | input | $clog2(DEPTH) | Window offset in samples, sampled with l1a |
| txData | output | 8 | Frame byte |
| txValid | output | 1 | txData holds a frame byte |
| txSof | output | 1 | First byte of a frame |
| txEof | output | 1 | Last byte of a frame |
| lostFlag | output | 1 | Sticky: an L1A was dropped |
| lostCount | output | 16 | Number of dropped L1As, saturating |

## Verification
The bench builds the block with four channels, a 16-sample window, a 256-row pipeline and a 4-event queue. This makes each frame 157 bytes, short enough that a full queue drains before the pipeline wraps. With these values, a burst of six L1As overruns the queue within a few cycles, and a minimum-latency window reaches right up to the write pointer. A per-channel ramp encodes the channel and the sample index in each word. As a result, any shift of the window by one row, or any swap of channels, shows up directly in the payload.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int SAMPLE_W = 12;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_PRE,
    SEL_SFD,
    SEL_HDR,
    SEL_PAY,
    SEL_FCS
  } byteSel_e;

  typedef struct packed {
    logic     emit;
    logic     sof;
    logic     eof;
    byteSel_e sel;
    logic     crcClear;
    logic     crcEn;
  } strobe_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] c;
    c = crcIn ^ {24'd0, dataIn};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int NUM_CH = 96,
  parameter int WIN    = 16,
  parameter int DEPTH  = 256,
  parameter int EVQ    = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WW    = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           l1a,
  input  logic [AW-1:0]  latency,
  input  logic [AW-1:0]  wrPtr,
  output strobe_t        strb,
  output logic [4:0]     hdrIdx,
  output logic [1:0]     fcsIdx,
  output logic [CHW-1:0] chanIdx,
  output logic [WW-1:0]  sampIdx,
  output logic           hiByte,
  output logic [AW-1:0]  rdBase,
  output logic [23:0]    evNum,
  output logic           lostFlag,
  output logic [15:0]    lostCount
);

  localparam int QW = (EVQ > 1) ? $clog2(EVQ) : 1;
  localparam int CW = $clog2(EVQ + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(EVQ);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_FCS} state_e;

  state_e          state;
  logic [4:0]      cnt;
  logic [AW-1:0]   qBase [EVQ];
  logic [23:0]     qNum  [EVQ];
  logic [QW-1:0]   head, tail;
  logic [CW-1:0]   count;
  logic [23:0]     l1aCnt;
  logic            push, pop, frameDone, queueFull;

  assign queueFull = (count == FULL_CNT);
  assign push      = l1a && !queueFull;
  assign frameDone = (state == ST_FCS) && (cnt == 5'd3);
  assign pop       = frameDone;

  // Event queue of window descriptors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      l1aCnt    <= '0;
      lostFlag  <= 1'b0;
      lostCount <= '0;
    end else begin
      if (l1a) l1aCnt <= l1aCnt + 24'd1;
      if (push) begin
        qBase[tail] <= wrPtr - latency;
        qNum[tail]  <= l1aCnt;
        tail        <= (tail == QW'(EVQ - 1)) ? '0 : tail + 1'b1;
      end
      if (l1a && queueFull) begin
        lostFlag <= 1'b1;
        if (lostCount != 16'hFFFF) lostCount <= lostCount + 16'd1;
      end
      if (pop) head <= (head == QW'(EVQ - 1)) ? '0 : head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdBase = qBase[head];
  assign evNum  = qNum[head];

  // Frame sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      chanIdx <= '0;
      sampIdx <= '0;
      hiByte  <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (count != '0) state <= ST_PRE;
        end
        ST_PRE: begin
          if (cnt == 5'd7) begin
            state <= ST_HDR;
            cnt   <= '0;
          end else cnt <= cnt + 5'd1;
        end
        ST_HDR: begin
          if (cnt == 5'd16) begin
            state   <= ST_PAY;
            cnt     <= '0;
            chanIdx <= '0;
            sampIdx <= '0;
            hiByte  <= 1'b1;
          end else cnt <= cnt + 5'd1;
        end
        ST_PAY: begin
          if (hiByte) hiByte <= 1'b0;
          else begin
            hiByte <= 1'b1;
            if (sampIdx == WW'(WIN - 1)) begin
              sampIdx <= '0;
              if (chanIdx == CHW'(NUM_CH - 1)) begin
                state <= ST_FCS;
                cnt   <= '0;
              end else chanIdx <= chanIdx + 1'b1;
            end else sampIdx <= sampIdx + 1'b1;
          end
        end
        ST_FCS: begin
          if (cnt == 5'd3) state <= ST_IDLE;
          else cnt <= cnt + 5'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    unique case (state)
      ST_PRE: begin
        strb.emit     = 1'b1;
        strb.sel      = (cnt == 5'd7) ? SEL_SFD : SEL_PRE;
        strb.sof      = (cnt == 5'd0);
        strb.crcClear = (cnt == 5'd0);
      end
      ST_HDR: begin
        strb.emit  = 1'b1;
        strb.sel   = SEL_HDR;
        strb.crcEn = 1'b1;
      end
      ST_PAY: begin
        strb.emit  = 1'b1;
        strb.sel   = SEL_PAY;
        strb.crcEn = 1'b1;
      end
      ST_FCS: begin
        strb.emit = 1'b1;
        strb.sel  = SEL_FCS;
        strb.eof  = (cnt == 5'd3);
      end
      default: strb = '0;
    endcase
  end

  assign hdrIdx = cnt;
  assign fcsIdx = cnt[1:0];

  // R8: queue occupancy never exceeds its capacity
  p_queue_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R8: an L1A meeting a full queue raises the loss flag
  p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    (l1a && queueFull) |=> lostFlag);

  // R8: loss flag is sticky until reset
  p_lost_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    lostFlag |=> lostFlag);

  // R3: a frame only starts when an event is waiting
  p_start_needs_event_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sof) |-> (count != '0));

endmodule

// File: rtl/sfp_data.sv
module sfp_data
  import sfp_pkg::*;
#(
  parameter int          NUM_CH    = 96,
  parameter int          WIN       = 16,
  parameter int          DEPTH     = 256,
  parameter logic [47:0] DEST_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC   = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETHERTYPE = 16'h88B5,
  localparam int AW  = $clog2(DEPTH),
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WW  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int RW  = NUM_CH * SAMPLE_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleStrobe,
  input  logic [RW-1:0]  sampleData,
  input  strobe_t        strb,
  input  logic [4:0]     hdrIdx,
  input  logic [1:0]     fcsIdx,
  input  logic [CHW-1:0] chanIdx,
  input  logic [WW-1:0]  sampIdx,
  input  logic           hiByte,
  input  logic [AW-1:0]  rdBase,
  input  logic [23:0]    evNum,
  output logic [AW-1:0]  wrPtr,
  output logic [7:0]     txData,
  output logic           txValid,
  output logic           txSof,
  output logic           txEof
);

  localparam int HB = 17;

  logic [RW-1:0]       ring [DEPTH];
  logic [AW-1:0]       rdAddr;
  logic [RW-1:0]       rdRow;
  logic [SAMPLE_W-1:0] rdSample;
  logic [15:0]         padded;
  logic [HB*8-1:0]     hdrVec;
  logic [7:0]          nextByte;
  logic [31:0]         crcReg;

  // Continuous sample pipeline
  always_ff @(posedge clk) begin
    if (sampleStrobe && rstN) ring[wrPtr] <= sampleData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrPtr <= '0;
    else if (sampleStrobe) wrPtr <= wrPtr + 1'b1;
  end

  assign rdAddr   = rdBase + AW'(sampIdx);
  assign rdRow    = ring[rdAddr];
  assign rdSample = rdRow[int'(chanIdx)*SAMPLE_W +: SAMPLE_W];
  assign padded   = {{(16 - SAMPLE_W){1'b0}}, rdSample};
  assign hdrVec   = {DEST_MAC, SRC_MAC, ETHERTYPE, evNum};

  always_comb begin
    unique case (strb.sel)
      SEL_PRE: nextByte = 8'h55;
      SEL_SFD: nextByte = 8'hD5;
      SEL_HDR: nextByte = hdrVec[(HB - 1 - int'(hdrIdx))*8 +: 8];
      SEL_PAY: nextByte = hiByte ? padded[15:8] : padded[7:0];
      SEL_FCS: nextByte = ~crcReg[int'(fcsIdx)*8 +: 8];
      default: nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) crcReg <= 32'hFFFF_FFFF;
    else if (strb.crcClear) crcReg <= 32'hFFFF_FFFF;
    else if (strb.crcEn) crcReg <= crcStep(crcReg, nextByte);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData  <= '0;
      txValid <= 1'b0;
      txSof   <= 1'b0;
      txEof   <= 1'b0;
    end else begin
      txData  <= strb.emit ? nextByte : 8'h00;
      txValid <= strb.emit;
      txSof   <= strb.sof;
      txEof   <= strb.eof;
    end
  end

  // R9: at least one idle cycle after each frame
  p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    txEof |=> !txValid);

  // R9: a frame always opens with the start marker
  p_open_marker_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> txSof);

  // R9: valid stays high until the end marker
  p_valid_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txEof) |=> txValid);

  // R9: markers only appear on valid bytes and never together
  p_marker_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txSof || txEof) |-> (txValid && !(txSof && txEof)));

endmodule

// File: rtl/sfp_top.sv
module sfp_top
  import sfp_pkg::*;
#(
  parameter int          NUM_CH    = 96,
  parameter int          WIN       = 16,
  parameter int          DEPTH     = 256,
  parameter int          EVQ       = 4,
  parameter logic [47:0] DEST_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC   = 48'h02_00_00_00_00_02,
  parameter logic [15:0] ETHERTYPE = 16'h88B5,
  localparam int AW  = $clog2(DEPTH),
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleStrobe,
  input  logic [NUM_CH*SAMPLE_W-1:0]   sampleData,
  input  logic                         l1a,
  input  logic [AW-1:0]                latency,
  output logic [7:0]                   txData,
  output logic                         txValid,
  output logic                         txSof,
  output logic                         txEof,
  output logic                         lostFlag,
  output logic [15:0]                  lostCount
);

  strobe_t        strb;
  logic [4:0]     hdrIdx;
  logic [1:0]     fcsIdx;
  logic [CHW-1:0] chanIdx;
  logic [WW-1:0]  sampIdx;
  logic           hiByte;
  logic [AW-1:0]  rdBase;
  logic [AW-1:0]  wrPtr;
  logic [23:0]    evNum;

  sfp_ctrl #(.NUM_CH(NUM_CH), .WIN(WIN), .DEPTH(DEPTH), .EVQ(EVQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .l1a(l1a), .latency(latency), .wrPtr(wrPtr),
    .strb(strb), .hdrIdx(hdrIdx), .fcsIdx(fcsIdx), .chanIdx(chanIdx),
    .sampIdx(sampIdx), .hiByte(hiByte), .rdBase(rdBase), .evNum(evNum),
    .lostFlag(lostFlag), .lostCount(lostCount)
  );

  sfp_data #(.NUM_CH(NUM_CH), .WIN(WIN), .DEPTH(DEPTH), .DEST_MAC(DEST_MAC),
             .SRC_MAC(SRC_MAC), .ETHERTYPE(ETHERTYPE)) u_data (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleData(sampleData),
    .strb(strb), .hdrIdx(hdrIdx), .fcsIdx(fcsIdx), .chanIdx(chanIdx),
    .sampIdx(sampIdx), .hiByte(hiByte), .rdBase(rdBase), .evNum(evNum),
    .wrPtr(wrPtr), .txData(txData), .txValid(txValid), .txSof(txSof), .txEof(txEof)
  );

endmodule

// File: tb/sfp_top_test.sv
`timescale 1ns/1ps
module sfp_top_test;

  localparam int NUM_CH = 4;
  localparam int WIN    = 16;
  localparam int DEPTH  = 256;
  localparam int EVQ    = 4;
  localparam int AW     = $clog2(DEPTH);
  localparam int FLEN   = 29 + 2 * NUM_CH * WIN;
  localparam int SPER   = 8;
  localparam logic [47:0] DMAC  = 48'h02_11_22_33_44_55;
  localparam logic [47:0] SMAC  = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [15:0] ETYPE = 16'h88B5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [NUM_CH*12-1:0] sampleData = '0;
  logic l1a = 1'b0;
  logic [AW-1:0] latency = '0;
  logic [7:0] txData;
  logic txValid, txSof, txEof, lostFlag;
  logic [15:0] lostCount;

  always #2 clk = ~clk;

  sfp_top #(.NUM_CH(NUM_CH), .WIN(WIN), .DEPTH(DEPTH), .EVQ(EVQ),
            .DEST_MAC(DMAC), .SRC_MAC(SMAC), .ETHERTYPE(ETYPE)) uut (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .sampleData(sampleData),
    .l1a(l1a), .latency(latency), .txData(txData), .txValid(txValid),
    .txSof(txSof), .txEof(txEof), .lostFlag(lostFlag), .lostCount(lostCount)
  );

  int checks = 0;
  int fails = 0;
  int nSamp = 0;
  int phase = 0;
  int totalL1a = 0;
  int pushed = 0;
  int framesDone = 0;
  int lostExp = 0;
  int expNum[$];
  int expFirst[$];
  logic [7:0] frm[$];
  bit reqL1a = 0;
  bit reqAlign = 0;
  int reqLat = 0;
  bit doneFlag = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ramp(input int c, input int n);
    return {c[3:0], n[7:0]};
  endfunction

  // Stimulus: periodic ramp strobes and requested L1A pulses
  always @(negedge clk) begin
    bit strobeNow;
    strobeNow = rstN && (phase == 0);
    sampleStrobe <= strobeNow;
    for (int c = 0; c < NUM_CH; c++) sampleData[c*12 +: 12] <= ramp(c, nSamp);
    l1a <= 1'b0;
    if (reqL1a && (!reqAlign || strobeNow)) begin
      l1a     <= 1'b1;
      latency <= AW'(reqLat);
      if ((pushed - framesDone) < EVQ) begin
        expNum.push_back(totalL1a);
        expFirst.push_back(nSamp - reqLat);   // R11: strobe of this cycle not counted
        pushed++;
      end else lostExp++;
      totalL1a++;
      reqL1a = 0;
    end
    if (strobeNow) nSamp++;
    phase = (phase + 1) % SPER;
  end

  task automatic fireL1a(input int lat, input bit align);
    @(posedge clk);
    reqLat = lat;
    reqAlign = align;
    reqL1a = 1;
    while (reqL1a) @(posedge clk);
  endtask

  function automatic logic [31:0] benchCrc();
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 8; i < FLEN - 4; i++) begin
      r = r ^ {24'd0, frm[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return ~r;
  endfunction

  task automatic checkFrame();
    int num, first;
    bit ok;
    logic [31:0] crcExp, crcGot;
    logic [15:0] v;
    check(expNum.size() > 0, "R3", "unexpected frame", 1, 0);
    if (expNum.size() == 0) return;
    num = expNum.pop_front();
    first = expFirst.pop_front();
    check(frm.size() == FLEN, "R4", "frame length", frm.size(), FLEN);
    if (frm.size() != FLEN) return;
    ok = 1;
    for (int i = 0; i < 7; i++) if (frm[i] != 8'h55) ok = 0;
    check(ok && frm[7] == 8'hD5, "R4", "preamble/SFD", frm[7], 8'hD5);
    check({frm[0+8], frm[9], frm[10], frm[11], frm[12], frm[13]} == DMAC &&
          {frm[14], frm[15], frm[16], frm[17], frm[18], frm[19]} == SMAC &&
          {frm[20], frm[21]} == ETYPE, "R4", "addresses/ethertype",
          {frm[20], frm[21]}, ETYPE);
    check({frm[22], frm[23], frm[24]} == num[23:0], "R7", "event number",
          {frm[22], frm[23], frm[24]}, num);
    ok = 1;
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < WIN; k++)
        if (frm[25 + 2*(c*WIN + k)][7:4] != 4'h0) ok = 0;
    check(ok, "R5", "sample padding zero", 0, 0);
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < WIN; k++) begin
        v = {frm[25 + 2*(c*WIN + k)], frm[26 + 2*(c*WIN + k)]};
        if (v != {4'h0, ramp(c, first + k)}) begin
          check(0, "R2", $sformatf("window ch%0d s%0d", c, k), v, {4'h0, ramp(c, first + k)});
          c = NUM_CH;
          break;
        end
      end
    checks++;  // R2 window position check for this frame
    crcExp = benchCrc();
    crcGot = {frm[FLEN-1], frm[FLEN-2], frm[FLEN-3], frm[FLEN-4]};
    check(crcGot == crcExp, "R6", "frame check sequence", crcGot, crcExp);
  endtask

  // Monitor: samples away from the active edge
  always @(posedge clk) begin
    #1;
    if (rstN && txValid) begin
      if (txSof) frm.delete();
      frm.push_back(txData);
      if (txEof) begin
        checkFrame();
        framesDone++;
      end
    end
  end

  task automatic waitDrain();
    int t = 0;
    while ((expNum.size() != 0 || pushed != framesDone) && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    check(expNum.size() == 0, "R3", "all accepted events framed", expNum.size(), 0);
  endtask

  task automatic waitSamples(input int n);
    repeat (n * SPER) @(posedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check(txValid == 1'b0, "R10", "txValid in reset", txValid, 0);
    check(lostFlag == 1'b0, "R10", "lostFlag in reset", lostFlag, 0);
    check(lostCount == 16'd0, "R10", "lostCount in reset", lostCount, 0);
    @(negedge clk);
    rstN = 1'b1;
    waitSamples(130);   // R1: fill pipeline well past the largest latency
    fireL1a(40, 0);  waitDrain();   // R2 mid latency
    fireL1a(100, 0); waitDrain();   // R2 long latency
    fireL1a(WIN, 0); waitDrain();   // R2 minimum latency, window ends at write pointer
    fireL1a(20, 1);  waitDrain();   // R11 L1A with strobe in same cycle
    fireL1a(30, 0);  fireL1a(30, 0); waitDrain();   // R3 consecutive overlapping windows
    for (int i = 0; i < 6; i++) fireL1a(40, 0);     // R8 overrun the queue
    waitDrain();
    #1;
    check(lostFlag == 1'b1, "R8", "lostFlag after overrun", lostFlag, 1);
    check(lostCount == 16'(lostExp) && lostExp == 2, "R8", "lostCount", lostCount, 2);
    fireL1a(50, 0); waitDrain();   // R7 numbering continues past dropped events
    check(lostFlag == 1'b1, "R8", "lostFlag sticky", lostFlag, 1);
    @(negedge clk);
    rstN = 1'b0;
    totalL1a = 0; pushed = 0; framesDone = 0; lostExp = 0;
    repeat (3) @(posedge clk);
    #1;
    check(lostFlag == 1'b0 && lostCount == 16'd0, "R10", "loss state after reset",
          lostCount, 0);
    @(negedge clk);
    rstN = 1'b1;
    waitSamples(60);
    fireL1a(40, 0); waitDrain();   // R10 event number restarts at 0
    finishRun();
  end

endmodule